// File: doc/BRIEF.md
# Aperture Page Remapping Table

This block turns bus addresses that fall inside a fixed window of the address map into physical addresses. The window starts at a parameterised base and covers a parameterised number of 4 KiB pages. Each page has one 32-bit entry in an on-block table. An entry holds a valid flag and a physical page frame number. Software loads the table through a small register port using indirect access. It first writes a page-aligned bus address inside the window to a pointer register. It then reads or writes a data register, and that access reaches the entry chosen by the pointer.

A separate lookup port accepts one bus address per cycle together with a strobe. One cycle later the block returns either a hit with the remapped address or a miss. Translation happens only while software has set the enable bit. With the enable bit clear, every lookup misses.

Top module: `aper_remap`

## Requirements
- R1: After reset, the enable bit is 0, the pointer register reads 0 and every table entry reads 0, and no lookup response is flagged.
- R2: The configuration register sits at offset 0x24. Bit 0 is the translation enable. A write stores bit 0, and a read returns the stored enable in bit 0 with all other bits 0.
- R3: The pointer register sits at offset 0x28. A write keeps bits 31..12 of the written value, and a read returns them with bits 11..0 as 0.
- R4: A write to the data register at offset 0x2c stores the whole 32-bit value into entry number (pointer − base) >> 12, provided the pointer lies inside the window.
- R5: A read of offset 0x2c returns the entry chosen by the current pointer.
- R6: The window covers base through base + pages×4096 − 1. While the pointer lies outside it, writes to 0x2c change no entry and reads of 0x2c return 0.
- R7: A lookup strobe in one cycle produces exactly one response strobe in the next cycle. No response strobe appears without a lookup.
- R8: Three conditions together give a hit: translation is enabled, the address lies inside the window, and bit 31 (valid) of the selected entry is set. On a hit the result is {0, entry[30:12], address[11:0]}, the hit flag is 1 and the miss flag is 0.
- R9: Every other lookup misses. This covers a disabled block, an address below the base or at or above the window end, and an entry with bit 31 clear. A miss gives hit 0, miss 1 and a result address of 0.
- R10: A lookup in the same cycle as a register write that changes its entry, or changes the enable bit, uses the values from before that write.
- R11: Reads of any other offset return 0, and writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regWrite | input | 1 | Register write strobe |
| regOffset | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regOffset (combinational) |
| reqValid | input | 1 | Lookup strobe |
| reqAddr | input | 32 | Bus address to translate |
| rspValid | output | 1 | Lookup result strobe, one cycle after reqValid |
| rspHit | output | 1 | Translation succeeded |
| rspMiss | output | 1 | Translation refused |
| rspAddr | output | 32 | Remapped physical address on a hit, 0 otherwise |

## Verification
Two events can land in the same clock edge. In one, a lookup arrives while software rewrites the entry that lookup selects. In the other, a lookup arrives while software clears the enable bit. The bench provokes each case by driving the register write and the lookup strobe on the same falling edge. It then expects the response to reflect the values from before the write. A second lookup of the same page follows, and the bench expects that one to show the new entry value or the new enable state.

// File: rtl/aper_pkg.sv
`timescale 1ns/1ps
package aper_pkg;
  localparam logic [7:0] OFS_CFG  = 8'h24;
  localparam logic [7:0] OFS_PTR  = 8'h28;
  localparam logic [7:0] OFS_DATA = 8'h2c;
  localparam int PAGE_SHIFT = 12;

  typedef struct packed {
    logic tblWe;      // store write data into the pointed entry
    logic enable;     // translation enable
    logic ptrInRange; // pointer lies inside the aperture
  } ctlStrb_t;
endpackage

// File: rtl/aper_ctrl.sv
`timescale 1ns/1ps
module aper_ctrl
  import aper_pkg::*;
#(
  parameter logic [31:0] APER_BASE  = 32'h5800_0000,
  parameter int          PAGE_COUNT = 16,
  parameter int          IDXW       = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWrite,
  input  logic [7:0]      regOffset,
  input  logic [31:0]     regWdata,
  output logic [31:0]     regRdata,
  input  logic [31:0]     tblRdata,
  output logic [IDXW-1:0] ptrIdx,
  output ctlStrb_t        strb
);
  localparam logic [32:0] APER_LIMIT = {1'b0, APER_BASE} + 33'(PAGE_COUNT) * 33'd4096;

  logic        cfgEn;
  logic [19:0] ptrPage;
  logic [31:0] ptrAddr;
  logic [31:0] ptrDiff;
  logic        ptrInRange;

  assign ptrAddr    = {ptrPage, 12'h000};
  assign ptrDiff    = ptrAddr - APER_BASE;
  assign ptrInRange = ({1'b0, ptrAddr} >= {1'b0, APER_BASE}) && ({1'b0, ptrAddr} < APER_LIMIT);
  assign ptrIdx     = ptrDiff[PAGE_SHIFT +: IDXW];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEn   <= 1'b0;
      ptrPage <= '0;
    end else if (regWrite) begin
      if (regOffset == OFS_CFG) cfgEn   <= regWdata[0];
      if (regOffset == OFS_PTR) ptrPage <= regWdata[31:12];
    end
  end

  always_comb begin
    strb.tblWe      = regWrite && (regOffset == OFS_DATA) && ptrInRange;
    strb.enable     = cfgEn;
    strb.ptrInRange = ptrInRange;
  end

  always_comb begin
    case (regOffset)
      OFS_CFG:  regRdata = {31'b0, cfgEn};
      OFS_PTR:  regRdata = ptrAddr;
      OFS_DATA: regRdata = ptrInRange ? tblRdata : 32'h0;
      default:  regRdata = 32'h0;
    endcase
  end

  AST_DATA_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.tblWe |=> (tblRdata == $past(regWdata))) else $error("data write lost"); // R4

  AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regOffset == OFS_CFG) |=>
      ((regOffset != OFS_CFG) || (regRdata == {31'b0, $past(regWdata[0])}))) else $error("cfg readback"); // R2
endmodule

// File: rtl/aper_dp.sv
`timescale 1ns/1ps
module aper_dp
  import aper_pkg::*;
#(
  parameter logic [31:0] APER_BASE  = 32'h5800_0000,
  parameter int          PAGE_COUNT = 16,
  parameter int          IDXW       = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrb_t        strb,
  input  logic [IDXW-1:0] ptrIdx,
  input  logic [31:0]     wdata,
  output logic [31:0]     tblRdata,
  input  logic            reqValid,
  input  logic [31:0]     reqAddr,
  output logic            rspValid,
  output logic            rspHit,
  output logic            rspMiss,
  output logic [31:0]     rspAddr
);
  localparam logic [32:0] APER_LIMIT = {1'b0, APER_BASE} + 33'(PAGE_COUNT) * 33'd4096;

  logic [31:0] tbl [PAGE_COUNT];

  for (genvar g = 0; g < PAGE_COUNT; g++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) tbl[g] <= '0;
      else if (strb.tblWe && ptrIdx == IDXW'(g)) tbl[g] <= wdata;
    end
  end

  assign tblRdata = (int'(ptrIdx) < PAGE_COUNT) ? tbl[ptrIdx] : 32'h0;

  logic [31:0]     reqDiff;
  logic [IDXW-1:0] reqIdx;
  logic            reqInRange;
  logic [31:0]     selEntry;
  logic            hitNow;

  assign reqDiff    = reqAddr - APER_BASE;
  assign reqIdx     = reqDiff[PAGE_SHIFT +: IDXW];
  assign reqInRange = ({1'b0, reqAddr} >= {1'b0, APER_BASE}) && ({1'b0, reqAddr} < APER_LIMIT);
  assign selEntry   = (int'(reqIdx) < PAGE_COUNT) ? tbl[reqIdx] : 32'h0;
  assign hitNow     = strb.enable && reqInRange && selEntry[31];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspMiss  <= 1'b0;
      rspAddr  <= '0;
    end else begin
      rspValid <= reqValid;
      rspHit   <= reqValid && hitNow;
      rspMiss  <= reqValid && !hitNow;
      rspAddr  <= (reqValid && hitNow) ? {1'b0, selEntry[30:12], reqAddr[11:0]} : 32'h0;
    end
  end

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid) else $error("missing response"); // R7
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid) else $error("spurious response"); // R7
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspHit ^ rspMiss)) else $error("hit/miss clash"); // R8
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> (rspAddr[11:0] == $past(reqAddr[11:0]))) else $error("offset altered"); // R8
  AST_MISS_OUT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqInRange) |=> (rspMiss && rspAddr == 32'h0)) else $error("out-of-window hit"); // R9
  AST_MISS_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !strb.enable) |=> rspMiss) else $error("hit while disabled"); // R9
endmodule

// File: rtl/aper_remap.sv
`timescale 1ns/1ps
module aper_remap
  import aper_pkg::*;
#(
  parameter logic [31:0] APER_BASE  = 32'h5800_0000,
  parameter int          PAGE_COUNT = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrite,
  input  logic [7:0]  regOffset,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        reqValid,
  input  logic [31:0] reqAddr,
  output logic        rspValid,
  output logic        rspHit,
  output logic        rspMiss,
  output logic [31:0] rspAddr
);
  localparam int IDXW = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1;

  ctlStrb_t        strb;
  logic [IDXW-1:0] ptrIdx;
  logic [31:0]     tblRdata;

  aper_ctrl #(.APER_BASE(APER_BASE), .PAGE_COUNT(PAGE_COUNT), .IDXW(IDXW)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regOffset(regOffset),
    .regWdata(regWdata), .regRdata(regRdata), .tblRdata(tblRdata),
    .ptrIdx(ptrIdx), .strb(strb)
  );

  aper_dp #(.APER_BASE(APER_BASE), .PAGE_COUNT(PAGE_COUNT), .IDXW(IDXW)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .ptrIdx(ptrIdx), .wdata(regWdata),
    .tblRdata(tblRdata), .reqValid(reqValid), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspHit(rspHit), .rspMiss(rspMiss), .rspAddr(rspAddr)
  );
endmodule

// File: tb/sim_aper_remap.sv
`timescale 1ns/1ps
module sim_aper_remap;
  localparam logic [31:0] BASE  = 32'h5800_0000;
  localparam int          PAGES = 16;
  localparam logic [31:0] WEND  = BASE + PAGES * 4096;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrite = 1'b0;
  logic [7:0] regOffset = 8'h0;
  logic [31:0] regWdata = 32'h0;
  logic [31:0] regRdata;
  logic reqValid = 1'b0;
  logic [31:0] reqAddr = 32'h0;
  logic rspValid, rspHit, rspMiss;
  logic [31:0] rspAddr;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] model [PAGES];
  logic modelEn = 1'b0;

  always #2 clk = ~clk;

  aper_remap #(.APER_BASE(BASE), .PAGE_COUNT(PAGES)) u0 (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regOffset(regOffset),
    .regWdata(regWdata), .regRdata(regRdata), .reqValid(reqValid), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspHit(rspHit), .rspMiss(rspMiss), .rspAddr(rspAddr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ofs, input logic [31:0] d);
    @(negedge clk);
    regWrite = 1'b1; regOffset = ofs; regWdata = d;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] ofs, output logic [31:0] d);
    @(negedge clk);
    regOffset = ofs;
    #1 d = regRdata;
  endtask

  function automatic logic [31:0] entryFor(input int i);
    logic [18:0] frame = 19'(i * 37 + 5);
    return {(i % 5 != 3), frame, 12'h000};
  endfunction

  function automatic logic [31:0] expAddr(input logic [31:0] a, input logic en);
    int idx;
    if (!en || a < BASE || a >= WEND) return 32'h0;
    idx = int'((a - BASE) >> 12);
    if (!model[idx][31]) return 32'h0;
    return {1'b0, model[idx][30:12], a[11:0]};
  endfunction

  task automatic lookup(input string req, input logic [31:0] a);
    logic [31:0] ea;
    logic eh;
    ea = expAddr(a, modelEn);
    eh = (ea != 32'h0) || (modelEn && a >= BASE && a < WEND && model[int'((a - BASE) >> 12)][31]);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    chk({req, " valid"}, {31'b0, rspValid}, 32'h1);
    chk({req, " hit"},   {31'b0, rspHit},   {31'b0, eh});
    chk({req, " miss"},  {31'b0, rspMiss},  {31'b0, !eh});
    chk({req, " addr"},  rspAddr, ea);
  endtask

  initial begin
    #(200000 * 4);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < PAGES; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    chk("R1 rspValid", {31'b0, rspValid}, 32'h0);
    rd(8'h24, d); chk("R1 cfg", d, 32'h0);
    rd(8'h28, d); chk("R1 ptr", d, 32'h0);
    for (int i = 0; i < PAGES; i++) begin
      wr(8'h28, BASE + i * 4096);
      rd(8'h2c, d); chk("R1 entry", d, 32'h0);
    end

    // R4 / R5: fill every entry, then read back
    for (int i = 0; i < PAGES; i++) begin
      wr(8'h28, BASE + i * 4096);
      wr(8'h2c, entryFor(i));
      model[i] = entryFor(i);
    end
    for (int i = PAGES - 1; i >= 0; i--) begin
      wr(8'h28, BASE + i * 4096);
      rd(8'h2c, d); chk("R4 R5 readback", d, model[i]);
    end

    // R3: pointer drops low bits
    wr(8'h28, BASE + 32'h3abc);
    rd(8'h28, d); chk("R3 pointer", d, BASE + 32'h3000);

    // R9: disabled lookups miss
    for (int i = 0; i < PAGES; i++) lookup("R9 disabled", BASE + i * 4096 + 32'h10);

    // R2: enable and read back
    wr(8'h24, 32'hffff_fffe);
    rd(8'h24, d); chk("R2 cfg low", d, 32'h0);
    wr(8'h24, 32'h0000_0001); modelEn = 1'b1;
    rd(8'h24, d); chk("R2 cfg set", d, 32'h1);

    // R8 / R9: sweep every page with varied offsets
    for (int i = 0; i < PAGES; i++) begin
      lookup("R8 sweep", BASE + i * 4096 + ((i * 32'h111) & 32'hfff));
      lookup("R8 sweep last byte", BASE + i * 4096 + 32'hfff);
    end
    lookup("R9 below base", BASE - 1);
    lookup("R9 page below", BASE - 4096);
    lookup("R9 window end", WEND);
    lookup("R9 far", 32'h0000_1234);
    lookup("R8 first byte", BASE);
    lookup("R8 last window byte", WEND - 1);

    // R6: pointer outside window
    wr(8'h28, BASE - 4096);
    wr(8'h2c, 32'hdead_beef);
    rd(8'h2c, d); chk("R6 read below", d, 32'h0);
    wr(8'h28, WEND);
    wr(8'h2c, 32'hcafe_f00d);
    rd(8'h2c, d); chk("R6 read above", d, 32'h0);
    for (int i = 0; i < PAGES; i++) begin
      wr(8'h28, BASE + i * 4096);
      rd(8'h2c, d); chk("R6 untouched", d, model[i]);
    end

    // R11: unknown offsets
    wr(8'h30, 32'hffff_ffff);
    wr(8'h20, 32'h0000_0000);
    rd(8'h30, d); chk("R11 read other", d, 32'h0);
    rd(8'h24, d); chk("R11 cfg kept", d, 32'h1);
    rd(8'h28, d); chk("R11 ptr kept", d, BASE + (PAGES - 1) * 4096);

    // R10: same-cycle entry rewrite and lookup
    wr(8'h28, BASE + 2 * 4096);
    @(negedge clk);
    regWrite = 1'b1; regOffset = 8'h2c; regWdata = 32'h8001_2000;
    reqValid = 1'b1; reqAddr = BASE + 2 * 4096 + 32'h345;
    @(negedge clk);
    regWrite = 1'b0; reqValid = 1'b0;
    chk("R10 old entry hit", {31'b0, rspHit}, 32'h1);
    chk("R10 old entry addr", rspAddr, {1'b0, entryFor(2)[30:12], 12'h345});
    model[2] = 32'h8001_2000;
    lookup("R10 new entry", BASE + 2 * 4096 + 32'h345);

    // R10: same-cycle disable and lookup
    @(negedge clk);
    regWrite = 1'b1; regOffset = 8'h24; regWdata = 32'h0;
    reqValid = 1'b1; reqAddr = BASE + 32'h77;
    @(negedge clk);
    regWrite = 1'b0; reqValid = 1'b0;
    chk("R10 old enable hit", {31'b0, rspHit}, 32'h1);
    chk("R10 old enable addr", rspAddr, {1'b0, model[0][30:12], 12'h077});
    modelEn = 1'b0;
    lookup("R10 now disabled", BASE + 32'h77);

    // R7: no response without request
    @(negedge clk);
    chk("R7 idle", {31'b0, rspValid}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule